// File: doc/BRIEF.md
# Multi-Width ALU with Status Flags

This block is the purely combinational execute stage of a small 20-bit processor datapath. Every operation reads a destination operand and a source operand at one of three widths: 8, 16 or 20 bits. It returns a result, a write-enable that says whether that result is to be stored, and a new status word. The status word holds four flags: carry, zero, negative and overflow. Each operation has its own mask of the flags it updates. Flags outside that mask, and every status bit that is not a flag, pass through unchanged.

The operations are binary add and subtract, both with and without carry-in, and compare. Decimal add works on packed BCD digits. The logical group is AND, bit test, bit clear, bit set and exclusive OR. The single-operand group is three right shifts, a byte swap and a byte sign extension. A branch-condition evaluator decodes a 3-bit condition against the incoming status word. It lets the same flags steer control flow. The caller handles operand fetch and writeback.

Top module: `mx_alu`

## Requirements
- R1: Size code `size_sel` selects the operand width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 20 bits. Both operands are masked to that width before use, and every result bit above the width is 0.
- R2: Opcode 0 (add) computes dst+src and opcode 1 (add with carry) computes dst+src+C. C is the carry out of the operand width. V is set when the signed sum does not fit in that width.
- R3: Opcode 2 (subtract) computes dst+~src+1 at the operand width, and opcode 3 (subtract with carry) uses C in place of the +1. C is the carry out, so C=1 means no borrow. V is set when the signed difference does not fit.
- R4: Opcode 4 (compare) sets the flags exactly as subtract does and drives `result_we` low. Opcode 7 (bit test) also drives `result_we` low. Every other opcode drives it high.
- R5: Opcode 5 (decimal add) adds packed BCD digits plus C. It uses two digits at byte size and four digits at the larger sizes. C is set when the sum exceeds 99 or 9999. V is left unchanged.
- R6: Opcode 6 (AND) and opcode 7 (bit test) form dst AND src. They set C when that value is nonzero and clear V.
- R7: Opcode 8 (bit clear, dst AND NOT src) and opcode 9 (bit set, dst OR src) return their result and leave the whole status word unchanged.
- R8: Opcode 10 (XOR) sets C when the result is nonzero. It sets V when both operands have their sign bit set at the operand width.
- R9: Opcodes 11, 12 and 13 shift the source right by one. Opcode 11 fills the MSB with the old C, opcode 12 keeps the MSB, and opcode 13 clears it. Each puts the old bit 0 into C and clears V.
- R10: Opcode 14 (byte swap) exchanges source bits 7:0 and 15:8, clears bits 19:16 and leaves the status word unchanged. Opcode 15 (sign extend) copies source bit 7 into bits 19:8, sets C when the result is nonzero and clears V.
- R11: For every opcode that updates flags, N is the MSB of the result at the operand width, and Z is set when the width-masked result is zero.
- R12: The flags sit at fixed status positions: C in bit 0, Z in bit 1, N in bit 2 and V in bit 8. All other status bits pass from `sr_in` to `sr_out` unchanged.
- R13: `branch_taken` evaluates `cond_sel` against `sr_in` as follows: 0 not-zero, 1 zero, 2 no-carry, 3 carry, 4 negative, 5 N equals V, 6 N differs from V, 7 always.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_in | input | 20 | Destination operand; first operand of two-operand operations |
| src_in | input | 20 | Source operand; the only operand of shifts, swap and sign extend |
| size_sel | input | 2 | Operand width code |
| op_sel | input | 4 | Operation code |
| sr_in | input | 16 | Current status word |
| cond_sel | input | 3 | Branch condition code |
| result_out | output | 20 | Operation result, masked to the operand width |
| result_we | output | 1 | High when the result should be written back |
| sr_out | output | 16 | Updated status word |
| branch_taken | output | 1 | Selected condition holds on `sr_in` |

## Verification
All four outputs are due in the same cycle as the inputs that produce them, because no register lies between any input and any output. The bench changes inputs only on the falling clock edge. It then waits one nanosecond for the logic to settle and compares against values worked out by hand from the requirements, so no check straddles a rising edge. The directed cases cover carries and overflow at each width, decimal carries at byte and word size, the opcodes that hold flags or hold back the write, and every branch code.

// File: rtl/mx_alu_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, encodings and the per-operation flag-update
// table of the multi-width ALU. Assumes a 20-bit datapath and a 16-bit
// status word with the flags at fixed positions.
package mx_alu_pkg;

    localparam int DATA_W     = 20;
    localparam int SR_W       = 16;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 16;
    localparam int BCD_DIGITS = 4;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 8;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBC = 4'd3,
        OP_CMP  = 4'd4,  OP_DADD = 4'd5,  OP_AND  = 4'd6,  OP_BIT  = 4'd7,
        OP_BIC  = 4'd8,  OP_BIS  = 4'd9,  OP_XOR  = 4'd10, OP_RRC  = 4'd11,
        OP_RRA  = 4'd12, OP_RRU  = 4'd13, OP_SWPB = 4'd14, OP_SXT  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_EXT = 2'd2, SZ_EXT_ALT = 2'd3
    } alu_size_e;

    typedef enum logic [2:0] {
        CC_NZ = 3'd0, CC_Z = 3'd1, CC_NC = 3'd2, CC_C = 3'd3,
        CC_N  = 3'd4, CC_GE = 3'd5, CC_LT = 3'd6, CC_ALWAYS = 3'd7
    } alu_cond_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    // Which flags each operation is allowed to change.
    function automatic alu_flags_t flag_update_mask(alu_op_e op);
        alu_flags_t m;
        case (op)
            OP_DADD:                 m = '{v: 1'b0, n: 1'b1, z: 1'b1, c: 1'b1};
            OP_BIC, OP_BIS, OP_SWPB: m = '{v: 1'b0, n: 1'b0, z: 1'b0, c: 1'b0};
            default:                 m = '{v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mx_alu_addsub.sv
`timescale 1ns/1ps
// Module: binary adder/subtractor at a run-time operand width.
// Assumes a_i and b_i are already masked to the width given by msk_i and
// that sgn_i is one-hot on the sign bit of that width.
module mx_alu_addsub #(
    parameter int DW = 20
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] msk_i,
    input  logic [DW-1:0] sgn_i,
    input  logic          sub_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o,
    output logic          ovf_o
);

    logic [DW-1:0] b_eff;
    logic [DW:0]   sum;
    logic          sa, sb, sr;

    // Form a + b' + cin, then take carry at the width and signed overflow.
    always_comb begin
        b_eff  = sub_i ? (~b_i & msk_i) : b_i;
        sum    = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
        res_o  = sum[DW-1:0] & msk_i;
        cout_o = |(sum & {sgn_i, 1'b0});
        sa     = |(a_i & sgn_i);
        sb     = |(b_eff & sgn_i);
        sr     = |(res_o & sgn_i);
        ovf_o  = (sa == sb) && (sr != sa);
    end

    // R2: a plain add that carries out must have wrapped below its operand.
    always_comb begin
        if (!sub_i && !cin_i && cout_o) begin
            a_r2_wrap_implies_carry: assert (res_o < a_i)
                else $error("add carried out without wrapping");
        end
    end

endmodule

// File: rtl/mx_alu_bcd.sv
`timescale 1ns/1ps
// Module: packed-BCD adder built as a ripple chain of decimal digit cells.
// Assumes every input digit is 0..9. In byte mode the decimal carry is
// taken after the second digit; the caller masks off the upper digits.
module mx_alu_bcd #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] a_i,
    input  logic [4*DIGITS-1:0] b_i,
    input  logic                cin_i,
    input  logic                byte_i,
    output logic [4*DIGITS-1:0] sum_o,
    output logic                cout_o
);

    localparam int BYTE_DIGITS = 2;

    logic [DIGITS:0] cy;

    assign cy[0] = cin_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] fix;

        // One decimal digit: binary add, then correct by ten when above nine.
        always_comb begin
            raw = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, cy[g]};
            fix = raw - 5'd10;
            cy[g+1] = (raw > 5'd9);
            sum_o[4*g +: 4] = (raw > 5'd9) ? fix[3:0] : raw[3:0];
        end

        // R5: valid decimal inputs always yield a valid decimal digit.
        always_comb begin
            if (a_i[4*g +: 4] <= 4'd9 && b_i[4*g +: 4] <= 4'd9) begin
                a_r5_digit_in_range: assert (sum_o[4*g +: 4] <= 4'd9)
                    else $error("decimal digit %0d out of range", g);
            end
        end
    end

    // Select the decimal carry for the active size.
    assign cout_o = byte_i ? cy[BYTE_DIGITS] : cy[DIGITS];

endmodule

// File: rtl/mx_alu_logic.sv
`timescale 1ns/1ps
// Module: logical operations, right shifts, byte swap and sign extension.
// Assumes dst_i and src_i are masked to the operand width, that sgn_i is
// one-hot on its sign bit, and that DW is at least 16. The C and V
// values given for flag-preserving opcodes are ignored by the caller.
module mx_alu_logic
    import mx_alu_pkg::*;
#(
    parameter int DW = 20
) (
    input  alu_op_e       op_i,
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] msk_i,
    input  logic [DW-1:0] sgn_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          c_o,
    output logic          v_o
);

    localparam logic [DW-1:0] LOW_BYTE = DW'((1 << BYTE_W) - 1);

    logic [DW-1:0] raw;
    logic [DW-1:0] swp;

    // Byte swap of the low word, zero above it.
    always_comb begin
        swp = '0;
        swp[WORD_W-1:0] = {src_i[BYTE_W-1:0], src_i[WORD_W-1:BYTE_W]};
    end

    // Select the operation and its carry/overflow values.
    always_comb begin
        raw = '0;
        c_o = cin_i;
        v_o = 1'b0;
        case (op_i)
            OP_AND, OP_BIT: begin
                raw = dst_i & src_i;
                c_o = |raw;
            end
            OP_BIC:  raw = dst_i & ~src_i;
            OP_BIS:  raw = dst_i | src_i;
            OP_XOR: begin
                raw = dst_i ^ src_i;
                c_o = |raw;
                v_o = (|(dst_i & sgn_i)) && (|(src_i & sgn_i));
            end
            OP_RRC: begin
                raw = (src_i >> 1) | (cin_i ? sgn_i : '0);
                c_o = src_i[0];
            end
            OP_RRA: begin
                raw = (src_i >> 1) | (src_i & sgn_i);
                c_o = src_i[0];
            end
            OP_RRU: begin
                raw = src_i >> 1;
                c_o = src_i[0];
            end
            OP_SWPB: raw = swp;
            OP_SXT: begin
                raw = src_i[BYTE_W-1] ? (src_i | ~LOW_BYTE) : (src_i & LOW_BYTE);
                c_o = |(raw & msk_i);
            end
            default: raw = '0;
        endcase
        res_o = raw & msk_i;
    end

endmodule

// File: rtl/mx_alu_cond.sv
`timescale 1ns/1ps
// Module: branch-condition evaluator working from the status flags.
// Assumes the flags have already been extracted from the status word.
module mx_alu_cond
    import mx_alu_pkg::*;
(
    input  alu_flags_t flags_i,
    input  alu_cond_e  cond_i,
    output logic       taken_o
);

    // Decode the condition code against the flags.
    always_comb begin
        case (cond_i)
            CC_NZ:   taken_o = !flags_i.z;
            CC_Z:    taken_o =  flags_i.z;
            CC_NC:   taken_o = !flags_i.c;
            CC_C:    taken_o =  flags_i.c;
            CC_N:    taken_o =  flags_i.n;
            CC_GE:   taken_o = (flags_i.n == flags_i.v);
            CC_LT:   taken_o = (flags_i.n != flags_i.v);
            default: taken_o = 1'b1;
        endcase
    end

    // R13: the unconditional code is always taken, and the two signed codes are complementary.
    always_comb begin
        if (cond_i == CC_ALWAYS) begin
            a_r13_always_taken: assert (taken_o)
                else $error("unconditional branch not taken");
        end
        if (cond_i == CC_LT) begin
            a_r13_lt_excludes_ge: assert (taken_o == (flags_i.n ^ flags_i.v))
                else $error("less-than disagrees with N xor V");
        end
    end

endmodule

// File: rtl/mx_alu.sv
`timescale 1ns/1ps
// Module: top of the multi-width ALU. It decodes the operand size,
// dispatches to the arithmetic, decimal and logic units, merges the new
// flags into the status word through the per-operation mask, and
// evaluates a branch condition on the incoming status word.
// Assumes DW >= 16 and that the flag positions fit inside SRW bits.
module mx_alu
    import mx_alu_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int SRW = SR_W
) (
    input  logic [DW-1:0]  dst_in,
    input  logic [DW-1:0]  src_in,
    input  logic [1:0]     size_sel,
    input  logic [3:0]     op_sel,
    input  logic [SRW-1:0] sr_in,
    input  logic [2:0]     cond_sel,
    output logic [DW-1:0]  result_out,
    output logic           result_we,
    output logic [SRW-1:0] sr_out,
    output logic           branch_taken
);

    localparam int BCD_W = 4 * BCD_DIGITS;

    alu_op_e       op;
    alu_size_e     sz;
    logic [DW-1:0] msk, sgn, dst_m, src_m;
    alu_flags_t    fl_in, upd;
    logic          is_sub, as_cin;
    logic [DW-1:0] as_res, lg_res;
    logic          as_c, as_v, lg_c, lg_v;
    logic [BCD_W-1:0] bcd_sum;
    logic          bcd_c;
    logic [DW-1:0] res;
    logic          c_new, v_new;

    assign op = alu_op_e'(op_sel);
    assign sz = alu_size_e'(size_sel);

    // Width mask and sign-bit select from the size code.
    always_comb begin
        msk = '0;
        case (sz)
            SZ_BYTE: msk[BYTE_W-1:0] = '1;
            SZ_WORD: msk[WORD_W-1:0] = '1;
            default: msk = '1;
        endcase
        sgn   = msk ^ (msk >> 1);
        dst_m = dst_in & msk;
        src_m = src_in & msk;
    end

    // Pull the flags out of the incoming status word.
    always_comb begin
        fl_in.c = sr_in[FLG_C];
        fl_in.z = sr_in[FLG_Z];
        fl_in.n = sr_in[FLG_N];
        fl_in.v = sr_in[FLG_V];
    end

    // Subtract select and carry-in for the binary unit.
    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
        if (op == OP_ADDC || op == OP_SUBC) as_cin = fl_in.c;
        else                                as_cin = is_sub;
    end

    mx_alu_addsub #(.DW(DW)) u_addsub (
        .a_i    (dst_m),
        .b_i    (src_m),
        .msk_i  (msk),
        .sgn_i  (sgn),
        .sub_i  (is_sub),
        .cin_i  (as_cin),
        .res_o  (as_res),
        .cout_o (as_c),
        .ovf_o  (as_v)
    );

    mx_alu_bcd #(.DIGITS(BCD_DIGITS)) u_bcd (
        .a_i    (dst_m[BCD_W-1:0]),
        .b_i    (src_m[BCD_W-1:0]),
        .cin_i  (fl_in.c),
        .byte_i (sz == SZ_BYTE),
        .sum_o  (bcd_sum),
        .cout_o (bcd_c)
    );

    mx_alu_logic #(.DW(DW)) u_logic (
        .op_i  (op),
        .dst_i (dst_m),
        .src_i (src_m),
        .msk_i (msk),
        .sgn_i (sgn),
        .cin_i (fl_in.c),
        .res_o (lg_res),
        .c_o   (lg_c),
        .v_o   (lg_v)
    );

    mx_alu_cond u_cond (
        .flags_i (fl_in),
        .cond_i  (alu_cond_e'(cond_sel)),
        .taken_o (branch_taken)
    );

    // Pick the unit output for this opcode.
    always_comb begin
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                res = as_res; c_new = as_c; v_new = as_v;
            end
            OP_DADD: begin
                res = {{(DW-BCD_W){1'b0}}, bcd_sum} & msk;
                c_new = bcd_c; v_new = fl_in.v;
            end
            default: begin
                res = lg_res; c_new = lg_c; v_new = lg_v;
            end
        endcase
    end

    // Drive the outputs and merge the new flags through the update mask.
    always_comb begin
        upd        = flag_update_mask(op);
        result_out = res;
        result_we  = !((op == OP_CMP) || (op == OP_BIT));
        sr_out     = sr_in;
        if (upd.c) sr_out[FLG_C] = c_new;
        if (upd.z) sr_out[FLG_Z] = ~|res;
        if (upd.n) sr_out[FLG_N] = |(res & sgn);
        if (upd.v) sr_out[FLG_V] = v_new;
    end

    // R1, R4, R7 and R12 checks on the merged outputs.
    always_comb begin
        a_r1_no_bits_above_width: assert ((result_out & ~msk) == '0)
            else $error("result has bits above the operand width");
        if (op == OP_CMP || op == OP_BIT) begin
            a_r4_no_write_on_test: assert (!result_we)
                else $error("compare or bit test requested a write");
        end
        if (op == OP_BIC || op == OP_BIS || op == OP_SWPB) begin
            a_r7_status_held: assert (sr_out == sr_in)
                else $error("flag-preserving opcode altered status");
        end
        for (int i = 0; i < SRW; i++) begin
            if (i != FLG_C && i != FLG_Z && i != FLG_N && i != FLG_V) begin
                a_r12_other_bits_pass: assert (sr_out[i] == sr_in[i])
                    else $error("non-flag status bit %0d changed", i);
            end
        end
    end

endmodule

// File: tb/sim_mx_alu.sv
`timescale 1ns/1ps
// Directed bench for mx_alu: one task per scenario, each checking its own results.
module sim_mx_alu;
    import mx_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] dst_in = '0, src_in = '0;
    logic [1:0]  size_sel = '0;
    logic [3:0]  op_sel = '0;
    logic [15:0] sr_in = '0;
    logic [2:0]  cond_sel = '0;
    logic [19:0] result_out;
    logic        result_we;
    logic [15:0] sr_out;
    logic        branch_taken;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mx_alu u0 (
        .dst_in(dst_in), .src_in(src_in), .size_sel(size_sel), .op_sel(op_sel),
        .sr_in(sr_in), .cond_sel(cond_sel), .result_out(result_out),
        .result_we(result_we), .sr_out(sr_out), .branch_taken(branch_taken)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive on the falling edge; outputs are combinational, sample 1 ns later.
    task automatic apply(input logic [3:0] op, input logic [1:0] sz,
                         input logic [19:0] d, input logic [19:0] s,
                         input logic [15:0] sr);
        @(negedge clk);
        op_sel = op; size_sel = sz; dst_in = d; src_in = s; sr_in = sr;
        #1;
    endtask

    task automatic expect_all(input string req, input logic [19:0] r,
                              input logic we, input logic [15:0] sr);
        chk(req, "result", 32'(result_out), 32'(r));
        chk(req, "we", 32'(result_we), 32'(we));
        chk(req, "sr", 32'(sr_out), 32'(sr));
    endtask

    task automatic t_idle();
        cond_sel = 3'd0;
        apply(OP_ADD, SZ_BYTE, 20'h0, 20'h0, 16'h0000);
        expect_all("R1 idle", 20'h0, 1'b1, 16'h0002);
        chk("R13 idle nz", "taken", 32'(branch_taken), 32'd1);
    endtask

    task automatic t_add();
        apply(OP_ADD, SZ_WORD, 20'h07FFF, 20'h00001, 16'h0000);
        expect_all("R2 word overflow", 20'h08000, 1'b1, 16'h0104);
        apply(OP_ADD, SZ_BYTE, 20'h123FF, 20'h00001, 16'h0000);
        expect_all("R1 byte mask carry", 20'h0, 1'b1, 16'h0003);
        apply(OP_ADD, SZ_EXT, 20'h80000, 20'h80000, 16'h0000);
        expect_all("R2 ext carry+V", 20'h0, 1'b1, 16'h0103);
        apply(OP_ADDC, SZ_EXT, 20'hFFFFF, 20'h0, 16'h0001);
        expect_all("R2 addc", 20'h0, 1'b1, 16'h0003);
    endtask

    task automatic t_sub();
        apply(OP_SUB, SZ_WORD, 20'h5, 20'h3, 16'h0000);
        expect_all("R3 no borrow", 20'h2, 1'b1, 16'h0001);
        apply(OP_SUB, SZ_WORD, 20'h3, 20'h5, 16'h0000);
        expect_all("R3 borrow", 20'h0FFFE, 1'b1, 16'h0004);
        apply(OP_SUB, SZ_BYTE, 20'h80, 20'h01, 16'h0000);
        expect_all("R3 byte overflow", 20'h7F, 1'b1, 16'h0101);
        apply(OP_SUBC, SZ_WORD, 20'h5, 20'h3, 16'h0000);
        expect_all("R3 subc C=0", 20'h1, 1'b1, 16'h0001);
    endtask

    task automatic t_cmp();
        apply(OP_CMP, SZ_WORD, 20'h7, 20'h7, 16'h0000);
        expect_all("R4 cmp equal", 20'h0, 1'b0, 16'h0003);
    endtask

    task automatic t_dadd();
        apply(OP_DADD, SZ_WORD, 20'h1234, 20'h5678, 16'h0100);
        expect_all("R5 word keep V", 20'h6912, 1'b1, 16'h0100);
        apply(OP_DADD, SZ_WORD, 20'h9999, 20'h0001, 16'h0000);
        expect_all("R5 word carry", 20'h0, 1'b1, 16'h0003);
        apply(OP_DADD, SZ_BYTE, 20'h95, 20'h05, 16'h0001);
        expect_all("R5 byte carry-in", 20'h01, 1'b1, 16'h0001);
    endtask

    task automatic t_logic();
        apply(OP_AND, SZ_WORD, 20'hF0F0, 20'h0FF0, 16'h0100);
        expect_all("R6 and", 20'h00F0, 1'b1, 16'h0001);
        apply(OP_BIT, SZ_WORD, 20'h00FF, 20'hFF00, 16'h0000);
        expect_all("R6 bit zero", 20'h0, 1'b0, 16'h0002);
        apply(OP_BIC, SZ_WORD, 20'hFFFF, 20'h00F0, 16'h0105);
        expect_all("R7 bic", 20'hFF0F, 1'b1, 16'h0105);
        apply(OP_BIS, SZ_BYTE, 20'h01, 20'h80, 16'h0000);
        expect_all("R7 bis", 20'h81, 1'b1, 16'h0000);
        apply(OP_XOR, SZ_WORD, 20'h8001, 20'h8000, 16'h0000);
        expect_all("R8 xor signs", 20'h0001, 1'b1, 16'h0101);
        apply(OP_XOR, SZ_BYTE, 20'h55, 20'h55, 16'h0000);
        expect_all("R8 xor zero", 20'h0, 1'b1, 16'h0002);
    endtask

    task automatic t_shift();
        apply(OP_RRC, SZ_WORD, 20'h0, 20'h0001, 16'h0001);
        expect_all("R9 rrc", 20'h8000, 1'b1, 16'h0005);
        apply(OP_RRA, SZ_BYTE, 20'h0, 20'h81, 16'h0000);
        expect_all("R9 rra", 20'hC0, 1'b1, 16'h0005);
        apply(OP_RRU, SZ_EXT, 20'h0, 20'h80000, 16'h0100);
        expect_all("R9 rru", 20'h40000, 1'b1, 16'h0000);
    endtask

    task automatic t_swap_sxt();
        apply(OP_SWPB, SZ_WORD, 20'h0, 20'h1234, 16'h0107);
        expect_all("R10 swpb", 20'h3412, 1'b1, 16'h0107);
        apply(OP_SXT, SZ_EXT, 20'h0, 20'h00080, 16'h0000);
        expect_all("R10 sxt neg", 20'hFFF80, 1'b1, 16'h0005);
        apply(OP_SXT, SZ_WORD, 20'h0, 20'h1F7F, 16'h0000);
        expect_all("R10 sxt pos", 20'h007F, 1'b1, 16'h0001);
    endtask

    task automatic t_other_bits();
        apply(OP_ADD, SZ_WORD, 20'h1, 20'h1, 16'hFEF8);
        expect_all("R12 pass-through", 20'h2, 1'b1, 16'hFEF8);
        chk("R11 N clear on positive", "sr_n", 32'(sr_out[2]), 32'd0);
    endtask

    task automatic cond_case(input logic [2:0] c, input logic [15:0] sr, input logic exp);
        @(negedge clk);
        cond_sel = c; sr_in = sr;
        #1;
        chk($sformatf("R13 cond %0d", c), "taken", 32'(branch_taken), 32'(exp));
    endtask

    task automatic t_branch();
        cond_case(3'd0, 16'h0002, 1'b0);
        cond_case(3'd1, 16'h0002, 1'b1);
        cond_case(3'd2, 16'h0001, 1'b0);
        cond_case(3'd3, 16'h0001, 1'b1);
        cond_case(3'd4, 16'h0004, 1'b1);
        cond_case(3'd5, 16'h0004, 1'b0);
        cond_case(3'd6, 16'h0004, 1'b1);
        cond_case(3'd5, 16'h0104, 1'b1);
        cond_case(3'd6, 16'h0104, 1'b0);
        cond_case(3'd7, 16'h0000, 1'b1);
        cond_case(3'd4, 16'h0000, 1'b0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_add();
        t_sub();
        t_cmp();
        t_dadd();
        t_logic();
        t_shift();
        t_swap_sxt();
        t_other_bits();
        t_branch();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule